// File: doc/BRIEF.md
# Host Bus Byte Mailbox

This block sits between an 8-bit host processor bus and a local controller clocked on its own. The host sees one 4 KiB window in its address map. A host write to any address in that window leaves a byte for the local side. A host read from the window collects a byte that the local side placed there earlier. Each direction has one byte of storage and a full flag. Every finished host access raises an interrupt toward the local controller. A write also records the low address byte, so local firmware can treat the window as up to 256 separate command slots.

The host side is combinational. The window decode is qualified by the host bus phase clock, and the single read/write line becomes a read strobe and a write strobe. During a decoded read the block drives the output byte with an output enable. The strobes, the data byte and the low address byte are sampled together into the local clock through a two-stage synchronizer. An access takes effect once, when its synchronized strobe falls.

Top module: `hbus_mailbox`

## Requirements
- R1: An access is decoded only when address bits 15..12 equal binary 1000 (host range 0x8000 to 0x8FFF). An access outside that range changes no flag, no register and no output, and never asserts `host_doe`.
- R2: An access is decoded only while `host_phi` is 1. With `host_phi` at 0, an address in the window is ignored in the same way as in R1.
- R3: During a decoded access with `host_rnw`=1, `host_doe` is 1 and `host_dout` equals the output byte. In every other case `host_doe` is 0 and `host_dout` is 0.
- R4: A decoded write with `host_rnw`=0 stores the data byte in the input register and sets `in_full`. Both are visible after the third rising clock edge that follows the end of the access.
- R5: When a decoded read ends, `out_full` clears with the same latency as R4.
- R6: A decoded write copies address bits 7..0 into `sub_addr`. Reads leave `sub_addr` unchanged.
- R7: Each decoded access that ends sets `irq`. `irq` stays set until a `loc_irq_ack` pulse clears it.
- R8: A `loc_rd_in` pulse clears `in_full` and `overflow`. A `loc_out_load` pulse stores `loc_out_data` as the output byte and sets `out_full`. On the same edge, a completing host access takes priority over these local clears.
- R9: A decoded write that ends while `in_full` is set overwrites the input byte and sets `overflow`. `overflow` stays set until R8 clears it.
- R10: An access takes effect once however many clock cycles it is held. One long write into an empty input register does not set `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 16 | Host address bus |
| host_rnw | input | 1 | Host read (1) / write (0) line |
| host_phi | input | 1 | Host bus phase clock; accesses are valid while it is high |
| host_din | input | 8 | Data driven by the host on writes |
| host_dout | output | 8 | Data driven to the host on reads |
| host_doe | output | 1 | Output enable for `host_dout` |
| loc_rd_in | input | 1 | Local pulse: input byte consumed |
| loc_out_load | input | 1 | Local pulse: load `loc_out_data` |
| loc_out_data | input | 8 | Byte to offer to the host |
| loc_irq_ack | input | 1 | Local pulse: clear the interrupt |
| loc_in_data | output | 8 | Last byte written by the host |
| in_full | output | 1 | Input byte not yet consumed |
| out_full | output | 1 | Output byte not yet read by the host |
| overflow | output | 1 | Sticky: a host write overwrote an unread byte |
| irq | output | 1 | Interrupt to the local controller |
| sub_addr | output | 8 | Address bits 7..0 of the last host write |

## Verification
The assertions assume the host keeps `host_rnw` steady for the whole of an access. They also assume no local pulse falls on the same edge as an access commit, and that each strobe stays high for at least two local clock cycles so the synchronizer sees it. The stimulus changes every host input only on a falling clock edge, holds each access for four or more cycles, and leaves several idle cycles between accesses. Local pulses are issued only while no commit is pending.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DATA_W = 8;
    localparam int SUB_W  = 8;

    // One synchronizer sample of the host side
    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [DATA_W-1:0] data;
        logic [SUB_W-1:0]  sub;
    } host_smp_t;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RD   = 2'd1,
        ACC_WR   = 2'd2
    } acc_e;

    function automatic logic window_hit(input logic [3:0] top, input logic [3:0] match);
        return top == match;
    endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
    parameter int AW        = 16,
    parameter int WIN_BITS  = 4,
    parameter logic [WIN_BITS-1:0] WIN_MATCH = 4'h8
) (
    input  logic [AW-1:0] addr,
    input  logic          phi,
    input  logic          rnw,
    output logic          rd_stb,
    output logic          wr_stb
);
    logic sel;

    always_comb begin
        sel    = phi && (addr[AW-1 -: WIN_BITS] == WIN_MATCH);
        rd_stb = sel && rnw;
        wr_stb = sel && !rnw;
    end
endmodule

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  mbx_pkg::host_smp_t smp_in,
    output mbx_pkg::acc_e      done,
    output mbx_pkg::host_smp_t done_smp
);
    import mbx_pkg::*;

    host_smp_t stg [STAGES];
    host_smp_t prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= smp_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= stg[STAGES-1];
    end

    // The access ends when its synchronized strobe falls
    always_comb begin
        done = ACC_NONE;
        if (prev_q.wr && !stg[STAGES-1].wr)      done = ACC_WR;
        else if (prev_q.rd && !stg[STAGES-1].rd) done = ACC_RD;
        done_smp = prev_q;
    end
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs (
    input  logic                          clk,
    input  logic                          rst,
    input  mbx_pkg::acc_e                 done,
    input  mbx_pkg::host_smp_t            done_smp,
    input  logic                          loc_rd_in,
    input  logic                          loc_out_load,
    input  logic [mbx_pkg::DATA_W-1:0]    loc_out_data,
    input  logic                          loc_irq_ack,
    output logic [mbx_pkg::DATA_W-1:0]    in_data,
    output logic                          in_full,
    output logic [mbx_pkg::DATA_W-1:0]    out_data,
    output logic                          out_full,
    output logic                          overflow,
    output logic                          irq,
    output logic [mbx_pkg::SUB_W-1:0]     sub_addr
);
    import mbx_pkg::*;

    logic wr_done, rd_done;
    assign wr_done = (done == ACC_WR);
    assign rd_done = (done == ACC_RD);

    // Input direction: host commit wins over a local clear
    always_ff @(posedge clk) begin
        if (rst) begin
            in_data  <= '0;
            in_full  <= 1'b0;
            overflow <= 1'b0;
            sub_addr <= '0;
        end else if (wr_done) begin
            in_data  <= done_smp.data;
            sub_addr <= done_smp.sub;
            in_full  <= 1'b1;
            if (in_full) overflow <= 1'b1;
        end else if (loc_rd_in) begin
            in_full  <= 1'b0;
            overflow <= 1'b0;
        end
    end

    // Output direction
    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= '0;
            out_full <= 1'b0;
        end else if (rd_done) begin
            out_full <= 1'b0;
        end else if (loc_out_load) begin
            out_data <= loc_out_data;
            out_full <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    irq <= 1'b0;
        else if (wr_done || rd_done) irq <= 1'b1;
        else if (loc_irq_ack)       irq <= 1'b0;
    end
endmodule

// File: rtl/hbus_mailbox.sv
module hbus_mailbox #(
    parameter int AW          = 16,
    parameter int WIN_BITS    = 4,
    parameter logic [WIN_BITS-1:0] WIN_MATCH = 4'h8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [AW-1:0] host_addr,
    input  logic         host_rnw,
    input  logic         host_phi,
    input  logic [7:0]   host_din,
    output logic [7:0]   host_dout,
    output logic         host_doe,
    input  logic         loc_rd_in,
    input  logic         loc_out_load,
    input  logic [7:0]   loc_out_data,
    input  logic         loc_irq_ack,
    output logic [7:0]   loc_in_data,
    output logic         in_full,
    output logic         out_full,
    output logic         overflow,
    output logic         irq,
    output logic [7:0]   sub_addr
);
    import mbx_pkg::*;

    logic      rd_stb, wr_stb;
    host_smp_t smp;
    acc_e      done;
    host_smp_t done_smp;
    logic [DATA_W-1:0] out_byte;

    mbx_decode #(.AW(AW), .WIN_BITS(WIN_BITS), .WIN_MATCH(WIN_MATCH)) dec_i (
        .addr(host_addr), .phi(host_phi), .rnw(host_rnw),
        .rd_stb(rd_stb), .wr_stb(wr_stb)
    );

    always_comb begin
        smp.rd   = rd_stb;
        smp.wr   = wr_stb;
        smp.data = host_din;
        smp.sub  = host_addr[SUB_W-1:0];
    end

    mbx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .smp_in(smp), .done(done), .done_smp(done_smp)
    );

    mbx_regs regs_i (
        .clk(clk), .rst(rst), .done(done), .done_smp(done_smp),
        .loc_rd_in(loc_rd_in), .loc_out_load(loc_out_load),
        .loc_out_data(loc_out_data), .loc_irq_ack(loc_irq_ack),
        .in_data(loc_in_data), .in_full(in_full),
        .out_data(out_byte), .out_full(out_full),
        .overflow(overflow), .irq(irq), .sub_addr(sub_addr)
    );

    assign host_doe  = rd_stb;
    assign host_dout = rd_stb ? out_byte : '0;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker (
    input logic       clk,
    input logic       rst,
    input logic       host_phi,
    input logic       host_rnw,
    input logic       host_doe,
    input logic       in_full,
    input logic       out_full,
    input logic       overflow,
    input logic       irq,
    input logic       loc_irq_ack,
    input logic [7:0] sub_addr
);
    a_r2_no_drive_phase_low: assert property (@(posedge clk) disable iff (rst)
        !host_phi |-> !host_doe);

    a_r3_drive_only_on_read: assert property (@(posedge clk) disable iff (rst)
        host_doe |-> host_rnw);

    a_r4_full_with_irq: assert property (@(posedge clk) disable iff (rst)
        $rose(in_full) |-> irq);

    a_r5_read_end_irq: assert property (@(posedge clk) disable iff (rst)
        $fell(out_full) |-> irq);

    a_r6_sub_moves_on_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(sub_addr) |-> (irq && in_full));

    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !loc_irq_ack) |=> irq);

    a_r9_overflow_needs_full: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> in_full);
endmodule

bind hbus_mailbox mbx_checker chk_i (
    .clk(clk), .rst(rst), .host_phi(host_phi), .host_rnw(host_rnw),
    .host_doe(host_doe), .in_full(in_full), .out_full(out_full),
    .overflow(overflow), .irq(irq), .loc_irq_ack(loc_irq_ack),
    .sub_addr(sub_addr)
);

// File: tb/hbus_mailbox_tb_top.sv
module hbus_mailbox_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] host_addr = '0;
    logic        host_rnw = 1'b1;
    logic        host_phi = 1'b0;
    logic [7:0]  host_din = '0;
    logic [7:0]  host_dout;
    logic        host_doe;
    logic        loc_rd_in = 1'b0, loc_out_load = 1'b0, loc_irq_ack = 1'b0;
    logic [7:0]  loc_out_data = '0;
    logic [7:0]  loc_in_data, sub_addr;
    logic        in_full, out_full, overflow, irq;

    always #4 clk = ~clk;

    hbus_mailbox dut_i (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_rnw(host_rnw),
        .host_phi(host_phi), .host_din(host_din), .host_dout(host_dout),
        .host_doe(host_doe), .loc_rd_in(loc_rd_in), .loc_out_load(loc_out_load),
        .loc_out_data(loc_out_data), .loc_irq_ack(loc_irq_ack),
        .loc_in_data(loc_in_data), .in_full(in_full), .out_full(out_full),
        .overflow(overflow), .irq(irq), .sub_addr(sub_addr)
    );

    int checks = 0;
    int fails  = 0;

    // Behavioural reference state
    logic [7:0] m_in_data, m_out_data, m_sub;
    logic       m_in_full, m_out_full, m_ovf, m_irq;
    int         pend_cnt = 0;
    logic       pend_wr;
    logic [7:0] pend_data, pend_sub;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_in_data = 0; m_out_data = 0; m_sub = 0;
            m_in_full = 0; m_out_full = 0; m_ovf = 0; m_irq = 0;
            pend_cnt = 0;
        end else begin
            if (loc_rd_in)    begin m_in_full = 0; m_ovf = 0; end
            if (loc_out_load) begin m_out_full = 1; m_out_data = loc_out_data; end
            if (loc_irq_ack)  m_irq = 0;
            if (pend_cnt > 0) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    m_irq = 1;
                    if (pend_wr) begin
                        if (m_in_full) m_ovf = 1;
                        m_in_full = 1; m_in_data = pend_data; m_sub = pend_sub;
                    end else begin
                        m_out_full = 0;
                    end
                end
            end
        end
    end

    // Per-clock comparison, away from both edges
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            logic dec;
            dec = host_phi && host_addr[15:12] == 4'b1000 && host_rnw;
            chk("R3", "host_doe", host_doe, dec);
            chk("R3", "host_dout", host_dout, dec ? m_out_data : 0);
            chk("R4", "in_full", in_full, m_in_full);
            chk("R4", "loc_in_data", loc_in_data, m_in_data);
            chk("R5", "out_full", out_full, m_out_full);
            chk("R6", "sub_addr", sub_addr, m_sub);
            chk("R7", "irq", irq, m_irq);
            chk("R9", "overflow", overflow, m_ovf);
        end
    end

    task automatic host_acc(input logic [15:0] a, input logic rnw, input logic [7:0] d,
                            input logic phi, input int hold);
        @(negedge clk);
        host_addr = a; host_rnw = rnw; host_din = d; host_phi = phi;
        repeat (hold) @(negedge clk);
        host_phi = 1'b0; host_addr = '0; host_rnw = 1'b1; host_din = '0;
        if (phi && a[15:12] == 4'b1000) begin
            pend_wr = !rnw; pend_data = d; pend_sub = a[7:0]; pend_cnt = 3;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk); loc_rd_in = 1'b1; @(negedge clk); loc_rd_in = 1'b0;
    endtask
    task automatic pulse_ack();
        @(negedge clk); loc_irq_ack = 1'b1; @(negedge clk); loc_irq_ack = 1'b0;
    endtask
    task automatic load_out(input logic [7:0] d);
        @(negedge clk); loc_out_data = d; loc_out_load = 1'b1;
        @(negedge clk); loc_out_load = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        chk("R4", "reset in_full", in_full, 0);
        chk("R7", "reset irq", irq, 0);
        chk("R3", "reset doe", host_doe, 0);

        // R8 load output, R3/R5 host read
        load_out(8'h5A);
        #2 chk("R8", "out_full after load", out_full, 1);
        host_acc(16'h8003, 1'b1, 8'h00, 1'b1, 4);
        #2 chk("R5", "out_full after read", out_full, 0);
        chk("R7", "irq after read", irq, 1);
        repeat (3) @(negedge clk);
        #2 chk("R7", "irq held without ack", irq, 1);
        pulse_ack();
        #2 chk("R7", "irq after ack", irq, 0);

        // R4/R6 write
        host_acc(16'h8012, 1'b0, 8'hC3, 1'b1, 4);
        #2 chk("R4", "in data", loc_in_data, 8'hC3);
        chk("R6", "sub_addr", sub_addr, 8'h12);
        pulse_ack();
        pulse_rd();
        #2 chk("R8", "in_full after local read", in_full, 0);

        // R10 long write into empty buffer
        host_acc(16'h80A7, 1'b0, 8'h11, 1'b1, 14);
        #2 chk("R10", "overflow after one long write", overflow, 0);
        // R9 second write while full
        host_acc(16'h8034, 1'b0, 8'h22, 1'b1, 4);
        #2 chk("R9", "overflow", overflow, 1);
        chk("R9", "overwritten byte", loc_in_data, 8'h22);
        pulse_rd();
        #2 chk("R8", "overflow cleared", overflow, 0);
        pulse_ack();

        // R1 outside the window
        host_acc(16'h9000, 1'b0, 8'h77, 1'b1, 4);
        host_acc(16'h0F34, 1'b0, 8'h78, 1'b1, 4);
        host_acc(16'hF003, 1'b1, 8'h00, 1'b1, 4);
        #2 chk("R1", "irq after outside accesses", irq, 0);
        chk("R1", "in_full after outside accesses", in_full, 0);

        // R2 phase low
        host_acc(16'h8055, 1'b0, 8'h99, 1'b0, 5);
        #2 chk("R2", "irq with phase low", irq, 0);
        chk("R2", "sub with phase low", sub_addr, 8'h34);

        // R6 read leaves sub_addr alone
        load_out(8'hE1);
        host_acc(16'h8077, 1'b1, 8'h00, 1'b1, 5);
        #2 chk("R6", "sub after read", sub_addr, 8'h34);
        chk("R5", "out_full after second read", out_full, 0);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule